// File: doc/BRIEF.md
# Long-Dividend Integer Divider

This block divides a double-width dividend, presented as a high word and a low word, by a single-width divisor. It yields a single-width quotient and remainder in either unsigned or two's-complement signed arithmetic. Alongside the numeric result it produces a five-bit condition-flag vector, derived from flags supplied with the request, and a divide-by-zero trap indication. The parameter `W` sets the word width, and its default is 32.

A request is issued by pulsing `start` while the unit is idle. The operands and incoming flags are captured on that edge. The unit first handles the cases that need no iteration: a zero divisor, a quotient that cannot fit in one word, and small dividends. Any remaining request runs a bit-serial restoring divide of `W` steps over unsigned magnitudes. A final fixup step restores the signs, checks the signed quotient range and builds the flags. Completion is marked by a one-cycle `done` pulse. The result outputs then hold their values until the next completion.

Top module: `wdiv_top`

## Requirements
- R1: With a zero divisor the unit raises `dz_trap` together with `done`. It returns the dividend high word as `remainder` and the low word as `quotient`, and `flags_out` equals the captured `flags_in`.
- R2: If the high word of the dividend magnitude is greater than or equal to the divisor magnitude, the request completes as an overflow without dividing. Magnitudes are the operands themselves in unsigned mode and their absolute values in signed mode.
- R3: On any overflow, `quotient` is the original low word and `remainder` is the original high word. `flags_out` keeps bits 4 (X), 3 (N) and 2 (Z) from `flags_in`, sets bit 1 (V) and clears bit 0 (C).
- R4: In unsigned mode a non-overflowing request returns floor(dividend / divisor) and dividend mod divisor.
- R5: In signed mode (`signed_mode`=1), the division is carried out on absolute values. The remainder takes the sign of the dividend, so it is negated when the dividend is negative.
- R6: In signed mode, a negative quotient is valid for magnitudes up to 2^(W-1). A positive quotient is valid only when its bit W-1 is clear. Any other signed result is reported as an overflow, in the form given in R3.
- R7: On a normal completion, `flags_out` bit 4 (X) is copied from `flags_in`. Bit 3 (N) is quotient bit W-1, bit 2 (Z) is set when the quotient is zero, and bits 1 (V) and 0 (C) are clear.
- R8: Latency, counting the edge that samples `start` as edge 1: `done` is high after edge 2 for a zero divisor or a pre-divide overflow. It is high after edge 3 when the magnitude high word is zero and the magnitude low word is below the divisor magnitude, a case that includes a zero dividend. It is high after edge W+3 for every other request.
- R9: `done` is high for exactly one cycle per request and `busy` is low whenever `done` is high. A `start` pulse while `busy` is high is ignored: the running request's result and latency are unaffected, and no extra completion follows.
- R10: During and right after reset, `busy`, `done` and `dz_trap` are low, and `quotient`, `remainder` and `flags_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, sampled only while idle |
| signed_mode | input | 1 | 1 = signed divide, 0 = unsigned |
| dividend_hi | input | W | Upper word of the dividend |
| dividend_lo | input | W | Lower word of the dividend |
| divisor | input | W | Divisor |
| flags_in | input | 5 | Incoming flags {X,N,Z,V,C} |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion strobe |
| dz_trap | output | 1 | Divide-by-zero trap, valid with done |
| quotient | output | W | Quotient, held until next completion |
| remainder | output | W | Remainder, held until next completion |
| flags_out | output | 5 | Resulting flags {X,N,Z,V,C} |

## Verification
Two of the block's checks can fire on the same completion: the post-divide signed range check and the sign restoration of the remainder. A negative dividend whose true quotient lands just outside the signed range gets a negated remainder computed in the same fixup cycle in which overflow must override everything. The bench uses a 4-bit word and sweeps every dividend, every divisor and both modes, so each case at the range edges is hit, including magnitude exactly 2^(W-1) with opposite and with equal signs. Each result is compared with a model in plain integer arithmetic that applies overflow ahead of sign restoration.

// File: rtl/wdiv_pkg.sv
// Package: shared encodings for the long-dividend divider.
// Assumes the five-bit flag vector order {X,N,Z,V,C}, msb first.
package wdiv_pkg;
    localparam int FLAG_W = 5;
    localparam int FL_X   = 4;
    localparam int FL_N   = 3;
    localparam int FL_Z   = 2;
    localparam int FL_V   = 1;
    localparam int FL_C   = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_RUN  = 2'd2,
        ST_FIX  = 2'd3
    } wdiv_state_e;
endpackage

// File: rtl/wdiv_sign_prep.sv
// Module: converts captured operands to unsigned magnitudes.
// Assumes operands are stable registers; purely combinational.
// In unsigned mode the operands pass through and both sign flags are 0.
module wdiv_sign_prep #(
    parameter int W = 32
) (
    input  logic         signed_mode,
    input  logic [W-1:0] dend_hi,
    input  logic [W-1:0] dend_lo,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] mag_hi,
    output logic [W-1:0] mag_lo,
    output logic [W-1:0] mag_dvs,
    output logic         neg_dend,
    output logic         neg_dvs
);
    localparam int DW = 2 * W;

    logic [DW-1:0] dend_full;
    logic [DW-1:0] dend_abs;

    // Record operand signs and form absolute values.
    always_comb begin
        dend_full = {dend_hi, dend_lo};
        neg_dend  = signed_mode & dend_hi[W-1];
        neg_dvs   = signed_mode & dvs[W-1];
        dend_abs  = neg_dend ? (~dend_full + {{(DW-1){1'b0}}, 1'b1}) : dend_full;
        mag_hi    = dend_abs[DW-1:W];
        mag_lo    = dend_abs[W-1:0];
        mag_dvs   = neg_dvs ? (~dvs + {{(W-1){1'b0}}, 1'b1}) : dvs;
    end
endmodule

// File: rtl/wdiv_core.sv
// Module: bit-serial restoring divider of W steps.
// Assumes rem_init < dvs_init (no quotient overflow) and dvs_init != 0.
// After load, each step cycle retires one quotient bit, msb first.
module wdiv_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] rem_init,
    input  logic [W-1:0] quo_init,
    input  logic [W-1:0] dvs_init,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         last
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dvs_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    trial;
    logic [W:0]    diff;
    logic          fits;

    // Form one trial subtraction of the shifted partial remainder.
    always_comb begin
        trial = {rem_q, quo_q[W-1]};
        diff  = trial - {1'b0, dvs_q};
        fits  = ~diff[W];
    end

    // Hold partial remainder, dividend/quotient shifter and step count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            rem_q <= rem_init;
            quo_q <= quo_init;
            dvs_q <= dvs_init;
            cnt_q <= CW'(W);
        end else if (step && cnt_q != '0) begin
            rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
            quo_q <= {quo_q[W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign quo  = quo_q;
    assign rem  = rem_q;
    assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/wdiv_fixup.sv
// Module: restores signs, checks signed quotient range, builds flags.
// Assumes unsigned magnitudes from a divide that did not overflow.
// Purely combinational; used in the final cycle of a request.
module wdiv_fixup
    import wdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              signed_mode,
    input  logic              neg_dend,
    input  logic              neg_dvs,
    input  logic [W-1:0]      q_mag,
    input  logic [W-1:0]      r_mag,
    input  logic [FLAG_W-1:0] flags_cap,
    output logic [W-1:0]      quo,
    output logic [W-1:0]      rem,
    output logic              range_ovf,
    output logic [FLAG_W-1:0] flags
);
    localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

    logic neg_quo;

    // Apply result signs and detect an out-of-range signed quotient.
    always_comb begin
        neg_quo = signed_mode & (neg_dend ^ neg_dvs);
        if (neg_quo) begin
            range_ovf = (q_mag > NEG_LIMIT);
            quo       = ~q_mag + {{(W-1){1'b0}}, 1'b1};
        end else begin
            range_ovf = signed_mode & q_mag[W-1];
            quo       = q_mag;
        end
        rem = (signed_mode & neg_dend) ? (~r_mag + {{(W-1){1'b0}}, 1'b1}) : r_mag;
    end

    // Build normal-completion flags from the signed quotient.
    always_comb begin
        flags       = '0;
        flags[FL_X] = flags_cap[FL_X];
        flags[FL_N] = quo[W-1];
        flags[FL_Z] = (quo == '0);
    end
endmodule

// File: rtl/wdiv_top.sv
// Module: long-dividend divider, start/done handshake.
// Sequence: IDLE -> PREP (special cases) -> RUN (W steps) -> FIX.
// Assumes start is ignored outside IDLE; outputs hold between completions.
module wdiv_top
    import wdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              signed_mode,
    input  logic [W-1:0]      dividend_hi,
    input  logic [W-1:0]      dividend_lo,
    input  logic [W-1:0]      divisor,
    input  logic [4:0]        flags_in,
    output logic              busy,
    output logic              done,
    output logic              dz_trap,
    output logic [W-1:0]      quotient,
    output logic [W-1:0]      remainder,
    output logic [4:0]        flags_out
);
    wdiv_state_e       state_q;
    logic [W-1:0]      cap_hi;
    logic [W-1:0]      cap_lo;
    logic [W-1:0]      cap_dvs;
    logic              cap_sgn;
    logic [FLAG_W-1:0] cap_flags;

    logic [W-1:0]      mag_hi;
    logic [W-1:0]      mag_lo;
    logic [W-1:0]      mag_dvs;
    logic              neg_dend;
    logic              neg_dvs;

    logic              go_dz;
    logic              go_ovf;
    logic              go_short;
    logic              core_load;
    logic              core_step;
    logic [W-1:0]      core_quo;
    logic [W-1:0]      core_rem;
    logic              core_last;

    logic              use_short;
    logic [W-1:0]      short_rem;
    logic [W-1:0]      fix_q_mag;
    logic [W-1:0]      fix_r_mag;
    logic [W-1:0]      fx_quo;
    logic [W-1:0]      fx_rem;
    logic              fx_ovf;
    logic [FLAG_W-1:0] fx_flags;
    logic [FLAG_W-1:0] ovf_flags;

    wdiv_sign_prep #(.W(W)) u_prep (
        .signed_mode (cap_sgn),
        .dend_hi     (cap_hi),
        .dend_lo     (cap_lo),
        .dvs         (cap_dvs),
        .mag_hi      (mag_hi),
        .mag_lo      (mag_lo),
        .mag_dvs     (mag_dvs),
        .neg_dend    (neg_dend),
        .neg_dvs     (neg_dvs)
    );

    // Classify the captured request in the PREP cycle.
    always_comb begin
        go_dz     = (cap_dvs == '0);
        go_ovf    = !go_dz && (mag_hi >= mag_dvs);
        go_short  = !go_dz && !go_ovf && (mag_hi == '0) && (mag_lo < mag_dvs);
        core_load = (state_q == ST_PREP) && !go_dz && !go_ovf && !go_short;
        core_step = (state_q == ST_RUN);
    end

    wdiv_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (core_load),
        .step     (core_step),
        .rem_init (mag_hi),
        .quo_init (mag_lo),
        .dvs_init (mag_dvs),
        .quo      (core_quo),
        .rem      (core_rem),
        .last     (core_last)
    );

    // Select magnitudes from the shortcut or the iterative core.
    always_comb begin
        fix_q_mag = use_short ? '0 : core_quo;
        fix_r_mag = use_short ? short_rem : core_rem;
    end

    wdiv_fixup #(.W(W)) u_fix (
        .signed_mode (cap_sgn),
        .neg_dend    (neg_dend),
        .neg_dvs     (neg_dvs),
        .q_mag       (fix_q_mag),
        .r_mag       (fix_r_mag),
        .flags_cap   (cap_flags),
        .quo         (fx_quo),
        .rem         (fx_rem),
        .range_ovf   (fx_ovf),
        .flags       (fx_flags)
    );

    // Overflow flags: keep X, N, Z; set V; clear C.
    always_comb begin
        ovf_flags       = cap_flags;
        ovf_flags[FL_V] = 1'b1;
        ovf_flags[FL_C] = 1'b0;
    end

    // Sequence the request and capture operands on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cap_hi    <= '0;
            cap_lo    <= '0;
            cap_dvs   <= '0;
            cap_sgn   <= 1'b0;
            cap_flags <= '0;
            use_short <= 1'b0;
            short_rem <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cap_hi    <= dividend_hi;
                        cap_lo    <= dividend_lo;
                        cap_dvs   <= divisor;
                        cap_sgn   <= signed_mode;
                        cap_flags <= flags_in;
                        state_q   <= ST_PREP;
                    end
                end
                ST_PREP: begin
                    use_short <= go_short;
                    short_rem <= mag_lo;
                    if (go_dz || go_ovf) begin
                        state_q <= ST_IDLE;
                    end else if (go_short) begin
                        state_q <= ST_FIX;
                    end else begin
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (core_last) begin
                        state_q <= ST_FIX;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Register results and the one-cycle completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            dz_trap   <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
            flags_out <= '0;
        end else begin
            done    <= 1'b0;
            dz_trap <= 1'b0;
            if (state_q == ST_PREP && go_dz) begin
                done      <= 1'b1;
                dz_trap   <= 1'b1;
                quotient  <= cap_lo;
                remainder <= cap_hi;
                flags_out <= cap_flags;
            end else if (state_q == ST_PREP && go_ovf) begin
                done      <= 1'b1;
                quotient  <= cap_lo;
                remainder <= cap_hi;
                flags_out <= ovf_flags;
            end else if (state_q == ST_FIX) begin
                done <= 1'b1;
                if (fx_ovf) begin
                    quotient  <= cap_lo;
                    remainder <= cap_hi;
                    flags_out <= ovf_flags;
                end else begin
                    quotient  <= fx_quo;
                    remainder <= fx_rem;
                    flags_out <= fx_flags;
                end
            end
        end
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/wdiv_checker.sv
// Module: temporal checks on the divider's handshake and flags.
// Attached to every wdiv_top instance through the bind below.
module wdiv_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic         dz_trap,
    input logic [W-1:0] quotient,
    input logic [4:0]   flags_out
);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(quotient));

    assert_trap_with_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dz_trap |-> done);

    assert_no_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dz_trap) |-> !flags_out[0]);

    assert_normal_zn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dz_trap && !flags_out[1]) |->
            (flags_out[2] == (quotient == '0)) && (flags_out[3] == quotient[W-1]));
endmodule

bind wdiv_top wdiv_checker #(.W(W)) u_wdiv_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .dz_trap   (dz_trap),
    .quotient  (quotient),
    .flags_out (flags_out)
);

// File: tb/tb_wdiv_top.sv
module tb_wdiv_top;
    localparam int BW = 4;
    localparam int HALF = 1 << (BW - 1);
    localparam int FULL = 1 << BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          signed_mode = 1'b0;
    logic [BW-1:0] dividend_hi = '0;
    logic [BW-1:0] dividend_lo = '0;
    logic [BW-1:0] divisor = '0;
    logic [4:0]    flags_in = '0;
    logic          busy;
    logic          done;
    logic          dz_trap;
    logic [BW-1:0] quotient;
    logic [BW-1:0] remainder;
    logic [4:0]    flags_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    wdiv_top #(.W(BW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .signed_mode (signed_mode),
        .dividend_hi (dividend_hi),
        .dividend_lo (dividend_lo),
        .divisor     (divisor),
        .flags_in    (flags_in),
        .busy        (busy),
        .done        (done),
        .dz_trap     (dz_trap),
        .quotient    (quotient),
        .remainder   (remainder),
        .flags_out   (flags_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 190000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model from the requirements, integer arithmetic.
    task automatic model(input int hi, input int lo, input int dv, input bit sg, input int fl,
                         output int eq, output int er, output int ef, output int et,
                         output int elat);
        int dend, sd, sv, md, mv, qm, rm, q, r;
        bit nd, nv, ovf;
        dend = hi * FULL + lo;
        et = 0;
        ovf = 0;
        if (dv == 0) begin
            eq = lo; er = hi; ef = fl; et = 1; elat = 2;
            return;
        end
        sd = (sg && hi >= HALF) ? dend - FULL * FULL : dend;
        sv = (sg && dv >= HALF) ? dv - FULL : dv;
        nd = sd < 0;
        nv = sv < 0;
        md = nd ? -sd : sd;
        mv = nv ? -sv : sv;
        if ((md / FULL) >= mv) begin
            eq = lo; er = hi; ef = (fl & 5'h1c) | 5'h02; elat = 2;
            return;
        end
        elat = ((md / FULL) == 0 && (md % FULL) < mv) ? 3 : BW + 3;
        qm = md / mv;
        rm = md % mv;
        if (sg && (nd != nv)) begin
            if (qm > HALF) ovf = 1;
            q = -qm;
        end else begin
            if (sg && qm >= HALF) ovf = 1;
            q = qm;
        end
        r = nd ? -rm : rm;
        if (ovf) begin
            eq = lo; er = hi; ef = (fl & 5'h1c) | 5'h02;
        end else begin
            eq = q & (FULL - 1);
            er = r & (FULL - 1);
            ef = (fl & 5'h10) | (((eq >> (BW - 1)) & 1) << 3) | ((eq == 0) ? 4 : 0);
        end
    endtask

    // Issue one request, optionally poking start while busy, and check it.
    task automatic run_op(input int hi, input int lo, input int dv, input bit sg, input int fl,
                          input bit poke);
        int eq, er, ef, et, elat, n;
        model(hi, lo, dv, sg, fl, eq, er, ef, et, elat);
        @(negedge clk);
        dividend_hi = BW'(hi);
        dividend_lo = BW'(lo);
        divisor = BW'(dv);
        signed_mode = sg;
        flags_in = 5'(fl);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 40) begin
            if (poke && n == 2) begin
                check(busy, "R9 busy during run", int'(busy), 1);
                dividend_hi = ~dividend_hi;
                dividend_lo = ~dividend_lo;
                divisor = divisor ^ BW'(1);
                flags_in = ~flags_in;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check(n == elat, "R8 latency", n, elat);
        check(int'(dz_trap) == et, "R1 trap", int'(dz_trap), et);
        if (et == 1) check(int'(flags_out) == ef, "R1 flags pass", int'(flags_out), ef);
        else if (ef[1]) check(int'(flags_out) == ef, "R3 overflow flags", int'(flags_out), ef);
        else check(int'(flags_out) == ef, "R7 normal flags", int'(flags_out), ef);
        if (ef[1] && et == 0) begin
            check(int'(quotient) == eq, "R2 R3 R6 overflow quotient", int'(quotient), eq);
            check(int'(remainder) == er, "R3 overflow remainder", int'(remainder), er);
        end else begin
            check(int'(quotient) == eq, sg ? "R5 R6 signed quotient" : "R4 quotient",
                  int'(quotient), eq);
            check(int'(remainder) == er, sg ? "R5 signed remainder" : "R4 remainder",
                  int'(remainder), er);
        end
        @(negedge clk);
        check(!done, "R9 done single cycle", int'(done), 0);
        if (poke) begin
            repeat (BW + 4) @(negedge clk) begin
                if (done) check(0, "R9 no extra completion", 1, 0);
            end
            check(!busy, "R9 ignored start left idle", int'(busy), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !dz_trap, "R10 reset controls", int'({busy, done, dz_trap}), 0);
        check(quotient == '0 && remainder == '0 && flags_out == '0, "R10 reset data",
              int'({quotient, remainder, flags_out}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R10 after release", int'({busy, done}), 0);

        // Start ignored while busy: full-length unsigned and signed runs.
        run_op(1, 7, 5, 1'b0, 5'h1f, 1'b1);
        run_op(15, 9, 3, 1'b1, 5'h03, 1'b1);

        // Exhaustive sweep of both modes, all dividends and divisors.
        for (int sg = 0; sg < 2; sg++) begin
            for (int d = 0; d < FULL * FULL; d++) begin
                for (int v = 0; v < FULL; v++) begin
                    run_op(d / FULL, d % FULL, v, sg[0], ((d * 3) + v + sg) & 31, 1'b0);
                end
            end
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule